// File: doc/BRIEF.md
# External Interrupt Controller with Noise Filter

This block watches four external interrupt lines and turns selected transitions or levels into pending requests, each tied to a fixed vector address. Every line passes through a two-flop synchroniser first. Lines 0 and 1 can trigger on a rising edge, a falling edge, a high level or a low level. Lines 2 and 3 can trigger on a rising edge, a falling edge or on both edges.

Line 3 also passes through a noise filter that samples at a selectable fraction of the clock. The filter accepts a new level only after two consecutive samples agree, so short glitches never reach the detector. The filtered level is also offered to a timer as a count input.

The CPU sees one request line and the vector of the highest-priority pending line. It clears an edge-mode request by strobing an acknowledge with that request's vector.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `pend_o` is 0, `irq_o` is 0, `vec_o` is 8'h00 and `tmr_evt_o` is 0.
- R2: For lines 0 and 1, the two mode bits `trig_mode_i[2i+1:2i]` select the trigger. 2'b00 means rising edge and 2'b01 means falling edge. In an edge mode, the pending bit is visible after the third rising clock edge that follows the pin change.
- R3: For lines 2 and 3, mode 2'b00 means rising edge, 2'b01 means falling edge, and 2'b10 or 2'b11 means both edges. No mode gives level triggering on these lines.
- R4: For lines 0 and 1, mode 2'b10 means active high and 2'b11 means active low. In a level mode the pending bit equals the synchronised level with one register of delay, and an acknowledge has no effect on it.
- R5: In an edge mode, a pending bit stays set until `ack_i` is high together with `ack_vec_i` equal to that line's vector. An acknowledge with another vector leaves the bit set. A new trigger in the same cycle as a matching acknowledge keeps the bit set.
- R6: The vectors are 8'h03, 8'h0B, 8'h13 and 8'h1B for lines 0 to 3. `vec_o` gives the vector of the lowest-numbered pending line and `irq_o` is high whenever any bit is pending. With nothing pending, `vec_o` is 8'h00.
- R7: A line whose `irq_en_i` bit is low has its pending bit cleared, and no new request is set for it.
- R8: `filt_sel_i` selects the filter sampling rate: 2'b00 samples every clock, 2'b01 every 16 clocks, and 2'b10 or 2'b11 every 64 clocks. The filtered level follows a new line-3 level only after two consecutive samples agree. At /16, a 10-cycle pulse is rejected and a 40-cycle pulse is accepted. At /64, a 40-cycle pulse is rejected and a 140-cycle pulse is accepted. At /1, a 1-cycle pulse is rejected and a 2-cycle pulse is accepted.
- R9: `tmr_evt_o` carries the filtered line-3 level, and line-3 trigger detection acts on that filtered level rather than on the raw pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 4 | External interrupt lines |
| irq_en_i | input | 4 | Per-line enable |
| trig_mode_i | input | 8 | Two trigger-mode bits per line |
| filt_sel_i | input | 2 | Line-3 filter sampling-rate select |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| pend_o | output | 4 | Pending request bits |
| irq_o | output | 1 | Any request pending |
| vec_o | output | 8 | Vector of the highest-priority pending line |
| tmr_evt_o | output | 1 | Filtered line-3 level for a timer |

## Verification
A wrong edge-detector history or synchroniser stage shows up within three clocks of a pin change. The pending bit either appears one cycle early or late, or appears on the wrong edge. A corrupted sample or prescaler count in the filter moves the cycle in which `tmr_evt_o` changes, or lets a glitch through, within two sampling periods. A wrong pending bit shows at once in `vec_o` and `irq_o`, because the priority encoder is combinational. The bench model runs in lockstep, so any such error is reported in the first cycle where the outputs differ.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NPIN     = 4;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_HIGH = 2'b10,
    TRG_LOW  = 2'b11
  } trig_e;

  // Vector address of line idx.
  function automatic logic [7:0] vec_of(input int idx);
    return 8'(VEC_BASE + VEC_STEP * idx);
  endfunction

  // Last count value of the sampling prescaler for a select code.
  function automatic int div_limit(input logic [1:0] sel, input int mid, input int hi);
    case (sel)
      2'b00:   return 0;
      2'b01:   return mid - 1;
      default: return hi - 1;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       lvl_i,
  output logic       tick_o,
  output logic       filt_o
);
  import irq_pkg::*;
  localparam int CW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

  logic [CW-1:0] cnt;
  logic          smp;
  logic [CW-1:0] lim;

  assign lim    = CW'(div_limit(sel_i, DIV_MID, DIV_HI));
  assign tick_o = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      smp    <= 1'b0;
      filt_o <= 1'b0;
    end else begin
      cnt <= tick_o ? '0 : cnt + 1'b1;
      if (tick_o) begin
        smp <= lvl_i;
        if (lvl_i == smp && lvl_i != filt_o) filt_o <= lvl_i;
      end
    end
  end
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       hit_o,
  output logic       act_o,
  output logic       lvl_mode_o
);
  import irq_pkg::*;
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;
  end

  assign rise = lvl_i & ~prev;
  assign fall = ~lvl_i & prev;

  generate
    if (LEVEL_OK) begin : g_level
      always_comb begin
        hit_o      = 1'b0;
        act_o      = 1'b0;
        lvl_mode_o = 1'b0;
        case (trig_e'(mode_i))
          TRG_RISE: hit_o = rise;
          TRG_FALL: hit_o = fall;
          TRG_HIGH: begin lvl_mode_o = 1'b1; act_o = lvl_i;  end
          default:  begin lvl_mode_o = 1'b1; act_o = ~lvl_i; end
        endcase
      end
    end else begin : g_dual
      assign lvl_mode_o = 1'b0;
      assign act_o      = 1'b0;
      assign hit_o      = (mode_i == 2'b00) ? rise :
                          (mode_i == 2'b01) ? fall : (rise | fall);
    end
  endgenerate
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_pin_i,
  input  logic [3:0] irq_en_i,
  input  logic [7:0] trig_mode_i,
  input  logic [1:0] filt_sel_i,
  input  logic       ack_i,
  input  logic [7:0] ack_vec_i,
  output logic [3:0] pend_o,
  output logic       irq_o,
  output logic [7:0] vec_o,
  output logic       tmr_evt_o
);
  import irq_pkg::*;

  logic [NPIN-1:0] sync_lvl;
  logic [NPIN-1:0] det_lvl;
  logic [NPIN-1:0] hit, act, lvl_mode, clr;
  logic            filt3, tick3;

  irq_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_pin_i), .q(sync_lvl)
  );

  irq_filter #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_filt (
    .clk(clk), .rst_n(rst_n), .sel_i(filt_sel_i), .lvl_i(sync_lvl[NPIN-1]),
    .tick_o(tick3), .filt_o(filt3)
  );

  assign tmr_evt_o = filt3;
  assign det_lvl   = {filt3, sync_lvl[NPIN-2:0]};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    irq_trigger #(.LEVEL_OK(i < 2)) u_trg (
      .clk(clk), .rst_n(rst_n), .lvl_i(det_lvl[i]),
      .mode_i(trig_mode_i[2*i +: 2]),
      .hit_o(hit[i]), .act_o(act[i]), .lvl_mode_o(lvl_mode[i])
    );
    assign clr[i] = ack_i && (ack_vec_i == vec_of(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_o[i] <= 1'b0;
      else if (!irq_en_i[i]) pend_o[i] <= 1'b0;
      else if (lvl_mode[i])  pend_o[i] <= act[i];
      else                   pend_o[i] <= hit[i] | (pend_o[i] & ~clr[i]);
    end
  end

  always_comb begin
    vec_o = 8'h00;
    for (int k = NPIN - 1; k >= 0; k--)
      if (pend_o[k]) vec_o = vec_of(k);
  end
  assign irq_o = |pend_o;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_en_i,
  input logic [7:0] trig_mode_i,
  input logic [3:0] pend_o,
  input logic       irq_o,
  input logic [7:0] vec_o,
  input logic [3:0] sync_lvl,
  input logic       filt3
);
  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_en_i[0]) && $past(trig_mode_i[1:0]) == 2'b10) |-> pend_o[0] == $past(sync_lvl[0]));

  assert_top_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[0] |-> vec_o == 8'h03);

  assert_idle_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == 4'b0) |-> (!irq_o && vec_o == 8'h00));

  assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~$past(irq_en_i)) == 4'b0);

  assert_filter_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt3) |-> filt3 == $past(sync_lvl[3]));
endmodule

bind ext_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en_i(irq_en_i), .trig_mode_i(trig_mode_i),
  .pend_o(pend_o), .irq_o(irq_o), .vec_o(vec_o), .sync_lvl(sync_lvl), .filt3(filt3)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b0, en = 4'b0;
  logic [7:0] mode = 8'h00, ackv = 8'h00;
  logic [1:0] sel = 2'b00;
  logic       ack = 1'b0;
  logic [3:0] pend_o;
  logic       irq_o, tmr_evt_o;
  logic [7:0] vec_o;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .irq_en_i(en),
    .trig_mode_i(mode), .filt_sel_i(sel), .ack_i(ack), .ack_vec_i(ackv),
    .pend_o(pend_o), .irq_o(irq_o), .vec_o(vec_o), .tmr_evt_o(tmr_evt_o)
  );

  // Behavioural reference model
  logic [3:0] hist[$];
  logic [3:0] m_pend;
  logic       m_smp, m_filt, m_fprev;
  int         phase;

  function automatic logic [7:0] exp_vec(input logic [3:0] p);
    for (int k = 0; k < 4; k++) if (p[k]) return 8'(3 + 8 * k);
    return 8'h00;
  endfunction

  always @(posedge clk) begin : model
    logic [3:0] s2, pv, np;
    logic lv, pr, trig, tick;
    logic [1:0] md;
    int lim;
    if (!rst_n) begin
      hist = {4'b0, 4'b0, 4'b0};
      m_pend = 4'b0; m_smp = 0; m_filt = 0; m_fprev = 0; phase = 0;
    end else begin
      s2 = hist[1]; pv = hist[2];
      for (int i = 0; i < 4; i++) begin
        lv = (i == 3) ? m_filt : s2[i];
        pr = (i == 3) ? m_fprev : pv[i];
        md = mode[2*i +: 2];
        if (i < 2 && md[1]) np[i] = md[0] ? !lv : lv;
        else begin
          if (md == 2'b00)      trig = lv && !pr;
          else if (md == 2'b01) trig = !lv && pr;
          else                  trig = lv != pr;
          np[i] = trig || (m_pend[i] && !(ack && ackv == 8'(3 + 8 * i)));
        end
        if (!en[i]) np[i] = 0;
      end
      lim = (sel == 2'b00) ? 0 : (sel == 2'b01) ? 15 : 63;
      tick = phase >= lim;
      m_fprev = m_filt;
      if (tick) begin
        if (s2[3] == m_smp && s2[3] != m_filt) m_filt = s2[3];
        m_smp = s2[3];
        phase = 0;
      end else phase++;
      m_pend = np;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(8'(pend_o), 8'(m_pend), "R5 pend vs model");
      chk(8'(irq_o), 8'(|m_pend), "R6 irq vs model");
      chk(vec_o, exp_vec(m_pend), "R6 vec vs model");
      chk(8'(tmr_evt_o), 8'(m_filt), "R9 filt vs model");
    end
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] v);
    ack = 1; ackv = v; step(1); ack = 0;
  endtask

  initial begin
    step(4);
    chk(8'(pend_o), 8'h0, "R1 pend");
    chk(8'(irq_o), 8'h0, "R1 irq");
    chk(vec_o, 8'h00, "R1 vec");
    chk(8'(tmr_evt_o), 8'h0, "R1 filt");
    rst_n = 1; en = 4'hF; mode = 8'h00; step(3);

    // R2 rising on line 0, latency three edges
    pins[0] = 1; step(2);
    chk(8'(pend_o[0]), 8'h0, "R2 not yet");
    step(1);
    chk(8'(pend_o[0]), 8'h1, "R2 rise pend");
    do_ack(8'h0B);
    chk(8'(pend_o[0]), 8'h1, "R5 wrong vector ignored");
    do_ack(8'h03);
    chk(8'(pend_o[0]), 8'h0, "R5 ack clears");
    // R5 set wins over clear
    pins[0] = 0; step(2); pins[0] = 1; step(3);
    pins[0] = 0; step(3); pins[0] = 1; step(2);
    do_ack(8'h03);
    chk(8'(pend_o[0]), 8'h1, "R5 set beats clear");
    do_ack(8'h03); pins[0] = 0; step(3);

    // R2 falling on line 1
    mode[3:2] = 2'b01; pins[1] = 1; step(4);
    chk(8'(pend_o[1]), 8'h0, "R2 rise ignored in fall mode");
    pins[1] = 0; step(3);
    chk(8'(pend_o[1]), 8'h1, "R2 fall pend");
    do_ack(8'h0B);

    // R4 level modes
    mode[1:0] = 2'b10; step(2);
    chk(8'(pend_o[0]), 8'h0, "R4 high idle");
    pins[0] = 1; step(3);
    chk(8'(pend_o[0]), 8'h1, "R4 high active");
    do_ack(8'h03);
    chk(8'(pend_o[0]), 8'h1, "R4 ack no effect");
    pins[0] = 0; step(3);
    chk(8'(pend_o[0]), 8'h0, "R4 high released");
    mode[3:2] = 2'b11; step(2);
    chk(8'(pend_o[1]), 8'h1, "R4 low active");
    pins[1] = 1; step(3);
    chk(8'(pend_o[1]), 8'h0, "R4 low released");
    mode[3:0] = 4'b0000; step(2);

    // R3 both edges on line 2
    mode[5:4] = 2'b10; pins[2] = 1; step(3);
    chk(8'(pend_o[2]), 8'h1, "R3 both rise");
    do_ack(8'h13); pins[2] = 0; step(3);
    chk(8'(pend_o[2]), 8'h1, "R3 both fall");
    do_ack(8'h13);
    mode[5:4] = 2'b01; pins[2] = 1; step(4);
    chk(8'(pend_o[2]), 8'h0, "R3 fall mode ignores rise");
    pins[2] = 0; step(3);
    chk(8'(pend_o[2]), 8'h1, "R3 fall mode");
    do_ack(8'h13); mode[5:4] = 2'b00;

    // R6 priority, filter at /1
    pins[1] = 0; step(3);
    pins[3:1] = 3'b111; step(10);
    chk(8'(pend_o), 8'h0E, "R6 three pending");
    chk(vec_o, 8'h0B, "R6 vec line1");
    do_ack(8'h0B); chk(vec_o, 8'h13, "R6 vec line2");
    do_ack(8'h13); chk(vec_o, 8'h1B, "R6 vec line3");
    do_ack(8'h1B); chk(8'(irq_o), 8'h0, "R6 irq idle");
    pins[3:1] = 3'b000; step(10);

    // R7 disabled line
    en[2] = 0; pins[2] = 1; step(5);
    chk(8'(pend_o[2]), 8'h0, "R7 disabled no set");
    pins[2] = 0; step(3); en[2] = 1; step(2);

    // R8 filter widths, R9 filtered event
    pins[3] = 1; step(1); pins[3] = 0; step(10);
    chk(8'(pend_o[3]), 8'h0, "R8 /1 reject 1 cycle");
    pins[3] = 1; step(2); pins[3] = 0; step(10);
    chk(8'(pend_o[3]), 8'h1, "R8 /1 accept 2 cycles");
    do_ack(8'h1B);
    sel = 2'b01; step(40);
    pins[3] = 1; step(10); pins[3] = 0; step(100);
    chk(8'(pend_o[3]), 8'h0, "R8 /16 reject 10");
    pins[3] = 1; step(40);
    pins[3] = 0; step(1);
    chk(8'(tmr_evt_o), 8'h1, "R9 filtered level high");
    step(100);
    chk(8'(pend_o[3]), 8'h1, "R9 /16 accept 40");
    chk(8'(tmr_evt_o), 8'h0, "R9 filtered level back low");
    do_ack(8'h1B);
    sel = 2'b10; step(140);
    pins[3] = 1; step(40); pins[3] = 0; step(300);
    chk(8'(pend_o[3]), 8'h0, "R8 /64 reject 40");
    pins[3] = 1; step(140); pins[3] = 0; step(300);
    chk(8'(pend_o[3]), 8'h1, "R8 /64 accept 140");
    do_ack(8'h1B); step(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule